// File: doc/BRIEF.md
# PCI Subtractive Decode Target Claim

This block sits beside the target side of a PCI bridge that plays the role of the subtractive decoder on its bus. It samples each address phase, watches DEVSEL# through the positive-decode window, and claims a transaction late when no other agent has answered. The window lasts a fixed number of clocks, three by default. Configuration, interrupt-acknowledge, special-cycle, dual-address and reserved commands are never taken. A software-visible disable input turns subtractive claiming off.

For claimed accesses that need a completion, the block answers with Retry. I/O commands are retried at once. Memory reads are retried only after the initial-latency timeout indication. The command, address and byte enables of the retried access go into a single request record, and a later delayed-completion engine works from that record. When the master repeats the access, the record is matched by positive decode in the address phase. If the completion is ready the access is claimed without Retry and the record is freed. If it is not ready, the access is retried again. Every subtractive claim also raises a non-prefetchable mark for the address.

Top module: `pci_subdec_claim`

## Requirements
- R1: A subtractive claim happens only when DEVSEL# is sampled high at each of the WINDOW (default 3) clock edges that follow the address edge, which is the edge where FRAME# is first sampled low from bus idle. DEVSEL# going low only after the window does not prevent the claim.
- R2: `claim` of a subtractive claim is high for exactly one cycle, the cycle after edge WINDOW counted from the address edge (edge 0), so that it is sampled at edge WINDOW+1.
- R3: The command is taken from C/BE#[3:0] at the address edge. Codes 0000 (interrupt acknowledge), 0001 (special cycle), 0100, 0101, 1000, 1001 (reserved), 1010, 1011 (configuration read and write) and 1101 (dual address) are never claimed subtractively.
- R4: `decode_off`, sampled at the address edge, disables subtractive claiming when high.
- R5: Codes 0010 (I/O read) and 0011 (I/O write) that are claimed subtractively get `retry` in the same cycle as `claim`.
- R6: Codes 0110, 1100 and 1110 (memory read, read multiple, read line) that are claimed subtractively get a one-cycle `retry` in the cycle after the first edge, at or after edge WINDOW+1, where `lat_timeout` is sampled high. Codes 0111 and 1111 (memory write, write-and-invalidate) are claimed with no `retry`.
- R7: When a subtractive `retry` is issued and the record is empty, the record takes the command and address from the address edge and the raw C/BE# from edge 1. `rec_valid` then stays high. While the record is valid, its fields never change.
- R8: If the record is valid and the address phase carries the recorded command and address, `claim` goes high in the cycle after edge 0 regardless of `decode_off`. With `dt_ready` high there is no `retry` and the record is freed in that same edge. With `dt_ready` low, `retry` comes with the claim and the record is kept.
- R9: `np_mark` is high together with `claim` for subtractive claims, and it stays low for record-match claims.
- R10: After reset, and after every transaction including one claimed by another agent, the block acts on no address phase until FRAME# and IRDY# are both sampled high. In reset, `claim`, `retry`, `np_mark` and `rec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME# as seen on the bus |
| irdy_n | input | 1 | IRDY# as seen on the bus |
| devsel_n | input | 1 | DEVSEL# as seen on the bus (other agents) |
| cbe_n | input | 4 | C/BE# lines: command at address edge, byte enables afterwards |
| ad | input | ADDR_W | AD lines, address at the address edge |
| decode_off | input | 1 | High disables subtractive claiming |
| lat_timeout | input | 1 | Initial-latency timeout has expired for the current access |
| dt_ready | input | 1 | Delayed completion for the held record is available |
| claim | output | 1 | One-cycle strobe: drive DEVSEL# for this access |
| retry | output | 1 | One-cycle strobe: terminate this access with Retry |
| np_mark | output | 1 | Claimed address is to be treated as non-prefetchable |
| rec_valid | output | 1 | Request record holds a pending delayed request |
| rec_cmd | output | 4 | Recorded command code |
| rec_addr | output | ADDR_W | Recorded address |
| rec_be_n | output | 4 | Recorded byte enables, active low |

## Verification
The assertions assume that a transaction starts only from bus idle, with FRAME# falling while IRDY# is high. They also assume that `decode_off` and C/BE# are meaningful only at the edges where the block samples them, and that `lat_timeout` matters only while a memory read is waiting. The stimulus keeps to this. Each access has one address edge and one data phase with IRDY# held low. Two idle edges follow before the next FRAME#. Other agents assert DEVSEL# only at a chosen edge, and the timeout is raised once per access and held. A sweep covers all sixteen command codes, both settings of the disable input, and DEVSEL# at each window edge, just after the window and never. Record-match re-attempts are mixed in with the completion both pending and ready.

// File: rtl/pci_subdec_pkg.sv
package pci_subdec_pkg;

   localparam int CBE_W = 4;

   typedef enum logic [1:0] {
      CLS_NONE       = 2'd0,
      CLS_RETRY_NOW  = 2'd1,
      CLS_RETRY_LATE = 2'd2,
      CLS_POST       = 2'd3
   } claim_cls_e;

   typedef enum logic [1:0] {
      ST_BUSY    = 2'd0,
      ST_IDLE    = 2'd1,
      ST_WINDOW  = 2'd2,
      ST_LATWAIT = 2'd3
   } claim_st_e;

   localparam logic [CBE_W-1:0] CMD_IO_RD   = 4'b0010;
   localparam logic [CBE_W-1:0] CMD_IO_WR   = 4'b0011;
   localparam logic [CBE_W-1:0] CMD_MEM_RD  = 4'b0110;
   localparam logic [CBE_W-1:0] CMD_MEM_WR  = 4'b0111;
   localparam logic [CBE_W-1:0] CMD_MEM_RDM = 4'b1100;
   localparam logic [CBE_W-1:0] CMD_MEM_RDL = 4'b1110;
   localparam logic [CBE_W-1:0] CMD_MEM_WRI = 4'b1111;

endpackage

// File: rtl/pci_subdec_cmd_class.sv
module pci_subdec_cmd_class
   import pci_subdec_pkg::*;
(
   input  logic [CBE_W-1:0] cmd,
   output claim_cls_e       cls
);

   always_comb begin
      unique case (cmd)
         CMD_IO_RD, CMD_IO_WR:                 cls = CLS_RETRY_NOW;
         CMD_MEM_RD, CMD_MEM_RDM, CMD_MEM_RDL: cls = CLS_RETRY_LATE;
         CMD_MEM_WR, CMD_MEM_WRI:              cls = CLS_POST;
         default:                              cls = CLS_NONE;
      endcase
   end

endmodule

// File: rtl/pci_subdec_req_record.sv
module pci_subdec_req_record
   import pci_subdec_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IGN_LSB   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [CBE_W-1:0]  cap_cmd,
   input  logic [ADDR_W-1:0] cap_addr,
   input  logic [CBE_W-1:0]  cap_be_n,
   input  logic              free_en,
   input  logic [CBE_W-1:0]  probe_cmd,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic              valid,
   output logic [CBE_W-1:0]  cmd_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CBE_W-1:0]  be_n_q
);

   logic addr_eq;

   generate
      if (IGN_LSB == 0) begin : g_full_match
         assign addr_eq = (probe_addr == addr_q);
      end else begin : g_part_match
         assign addr_eq = (probe_addr[ADDR_W-1:IGN_LSB] == addr_q[ADDR_W-1:IGN_LSB]);
      end
   endgenerate

   assign probe_hit = valid && (probe_cmd == cmd_q) && addr_eq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         cmd_q  <= '0;
         addr_q <= '0;
         be_n_q <= '0;
      end else if (free_en) begin
         valid <= 1'b0;
      end else if (cap_en && !valid) begin
         valid  <= 1'b1;
         cmd_q  <= cap_cmd;
         addr_q <= cap_addr;
         be_n_q <= cap_be_n;
      end
   end

endmodule

// File: rtl/pci_subdec_window_fsm.sv
module pci_subdec_window_fsm
   import pci_subdec_pkg::*;
#(
   parameter int WINDOW = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic       irdy_n,
   input  logic       devsel_n,
   input  logic       off_q,
   input  logic       lat_timeout,
   input  logic       dt_ready,
   input  logic       rec_hit,
   input  claim_cls_e cls,
   output logic       addr_stb,
   output logic       be_stb,
   output logic       cap_req,
   output logic       free_req,
   output logic       claim,
   output logic       retry,
   output logic       np_mark
);

   localparam int CNT_W = $clog2(WINDOW + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   claim_st_e        st;
   logic [CNT_W-1:0] cnt;
   logic             win_end;
   logic             win_take;

   assign addr_stb = (st == ST_IDLE) && !frame_n;
   assign be_stb   = (st == ST_WINDOW) && (cnt == CNT_ONE);
   assign win_end  = (st == ST_WINDOW) && devsel_n && (cnt == CNT_LAST);
   assign win_take = win_end && (cls != CLS_NONE) && !off_q;
   assign cap_req  = (win_take && (cls == CLS_RETRY_NOW)) ||
                     ((st == ST_LATWAIT) && lat_timeout);
   assign free_req = addr_stb && rec_hit && dt_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_BUSY;
         cnt     <= '0;
         claim   <= 1'b0;
         retry   <= 1'b0;
         np_mark <= 1'b0;
      end else begin
         claim   <= 1'b0;
         retry   <= 1'b0;
         np_mark <= 1'b0;
         unique case (st)
            ST_BUSY: begin
               if (frame_n && irdy_n) st <= ST_IDLE;
            end
            ST_IDLE: begin
               if (!frame_n) begin
                  if (rec_hit) begin
                     claim <= 1'b1;
                     retry <= !dt_ready;
                     st    <= ST_BUSY;
                  end else begin
                     cnt <= CNT_ONE;
                     st  <= ST_WINDOW;
                  end
               end
            end
            ST_WINDOW: begin
               if (!devsel_n) begin
                  st <= ST_BUSY;
               end else if (cnt == CNT_LAST) begin
                  st <= ST_BUSY;
                  if (win_take) begin
                     claim   <= 1'b1;
                     np_mark <= 1'b1;
                     if (cls == CLS_RETRY_NOW)  retry <= 1'b1;
                     if (cls == CLS_RETRY_LATE) st    <= ST_LATWAIT;
                  end
               end else begin
                  cnt <= cnt + CNT_ONE;
               end
            end
            ST_LATWAIT: begin
               if (lat_timeout) begin
                  retry <= 1'b1;
                  st    <= ST_BUSY;
               end
            end
            default: st <= ST_BUSY;
         endcase
      end
   end

endmodule

// File: rtl/pci_subdec_claim.sv
module pci_subdec_claim
   import pci_subdec_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int WINDOW  = 3,
   parameter int IGN_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic              devsel_n,
   input  logic [3:0]        cbe_n,
   input  logic [ADDR_W-1:0] ad,
   input  logic              decode_off,
   input  logic              lat_timeout,
   input  logic              dt_ready,
   output logic              claim,
   output logic              retry,
   output logic              np_mark,
   output logic              rec_valid,
   output logic [3:0]        rec_cmd,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [3:0]        rec_be_n
);

   generate
      if (WINDOW < 1 || WINDOW > 7) begin : g_bad_window
         $error("pci_subdec_claim: WINDOW must be within 1..7");
      end
      if (IGN_LSB < 0 || IGN_LSB >= ADDR_W) begin : g_bad_ign
         $error("pci_subdec_claim: IGN_LSB must be below ADDR_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pci_subdec_claim: ADDR_W too small");
      end
   endgenerate

   logic [CBE_W-1:0]  cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CBE_W-1:0]  be_n_q;
   logic              off_q;
   logic              addr_stb;
   logic              be_stb;
   logic              cap_req;
   logic              free_req;
   logic              rec_hit;
   claim_cls_e        cls;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         addr_q <= '0;
         be_n_q <= '1;
         off_q  <= 1'b0;
      end else begin
         if (addr_stb) begin
            cmd_q  <= cbe_n;
            addr_q <= ad;
            off_q  <= decode_off;
         end
         if (be_stb) be_n_q <= cbe_n;
      end
   end

   pci_subdec_cmd_class u_cls (
      .cmd (cmd_q),
      .cls (cls)
   );

   pci_subdec_window_fsm #(.WINDOW(WINDOW)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_n     (frame_n),
      .irdy_n      (irdy_n),
      .devsel_n    (devsel_n),
      .off_q       (off_q),
      .lat_timeout (lat_timeout),
      .dt_ready    (dt_ready),
      .rec_hit     (rec_hit),
      .cls         (cls),
      .addr_stb    (addr_stb),
      .be_stb      (be_stb),
      .cap_req     (cap_req),
      .free_req    (free_req),
      .claim       (claim),
      .retry       (retry),
      .np_mark     (np_mark)
   );

   pci_subdec_req_record #(.ADDR_W(ADDR_W), .IGN_LSB(IGN_LSB)) u_rec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (cap_req),
      .cap_cmd    (cmd_q),
      .cap_addr   (addr_q),
      .cap_be_n   (be_n_q),
      .free_en    (free_req),
      .probe_cmd  (cbe_n),
      .probe_addr (ad),
      .probe_hit  (rec_hit),
      .valid      (rec_valid),
      .cmd_q      (rec_cmd),
      .addr_q     (rec_addr),
      .be_n_q     (rec_be_n)
   );

endmodule

// File: rtl/pci_subdec_claim_chk.sv
module pci_subdec_claim_chk #(
   parameter int ADDR_W = 32,
   parameter int WINDOW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic              irdy_n,
   input logic              devsel_n,
   input logic [3:0]        cbe_n,
   input logic              decode_off,
   input logic              lat_timeout,
   input logic              claim,
   input logic              retry,
   input logic              np_mark,
   input logic              rec_valid,
   input logic [3:0]        rec_cmd,
   input logic [ADDR_W-1:0] rec_addr,
   input logic [3:0]        rec_be_n
);

   logic       idle_q;
   logic [3:0] age;
   logic       dseen;
   logic       off_s;
   logic [3:0] cmd_s;
   logic       cmd_excl;
   logic       cmd_io;
   logic       cmd_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
         age    <= 4'hF;
         dseen  <= 1'b1;
         off_s  <= 1'b1;
         cmd_s  <= 4'h0;
      end else begin
         idle_q <= frame_n && irdy_n;
         if (idle_q && !frame_n) begin
            age   <= 4'h0;
            dseen <= 1'b0;
            off_s <= decode_off;
            cmd_s <= cbe_n;
         end else begin
            if (age != 4'hF) age <= age + 4'h1;
            if ((int'(age) < WINDOW) && !devsel_n) dseen <= 1'b1;
         end
      end
   end

   assign cmd_excl = (cmd_s inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB, 4'hD});
   assign cmd_io   = (cmd_s inside {4'h2, 4'h3});
   assign cmd_wr   = (cmd_s inside {4'h7, 4'hF});

   assert_silent_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      np_mark |-> (!dseen && (int'(age) == WINDOW)));

   assert_claim_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      claim |=> !claim);

   assert_excluded_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      np_mark |-> !cmd_excl);

   assert_decode_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      np_mark |-> !off_s);

   assert_io_retry_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (np_mark && cmd_io) |-> retry);

   assert_late_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (retry && !claim) |-> $past(lat_timeout));

   assert_write_posted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (np_mark && cmd_wr) |-> !retry);

   assert_record_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && $past(rec_valid)) |->
         ($stable(rec_cmd) && $stable(rec_addr) && $stable(rec_be_n)));

   assert_np_with_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
      np_mark |-> claim);

endmodule

bind pci_subdec_claim pci_subdec_claim_chk #(.ADDR_W(ADDR_W), .WINDOW(WINDOW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_n     (frame_n),
   .irdy_n      (irdy_n),
   .devsel_n    (devsel_n),
   .cbe_n       (cbe_n),
   .decode_off  (decode_off),
   .lat_timeout (lat_timeout),
   .claim       (claim),
   .retry       (retry),
   .np_mark     (np_mark),
   .rec_valid   (rec_valid),
   .rec_cmd     (rec_cmd),
   .rec_addr    (rec_addr),
   .rec_be_n    (rec_be_n)
);

// File: tb/pci_subdec_claim_tb_top.sv
module pci_subdec_claim_tb_top;

   localparam int ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_n = 1'b1;
   logic              irdy_n = 1'b1;
   logic              devsel_n = 1'b1;
   logic [3:0]        cbe_n = 4'hF;
   logic [ADDR_W-1:0] ad = '0;
   logic              decode_off = 1'b0;
   logic              lat_timeout = 1'b0;
   logic              dt_ready = 1'b0;
   logic              claim, retry, np_mark, rec_valid;
   logic [3:0]        rec_cmd, rec_be_n;
   logic [ADDR_W-1:0] rec_addr;

   int nchk = 0;
   int nfail = 0;

   bit              m_v = 1'b0;
   logic [3:0]      m_cmd;
   logic [ADDR_W-1:0] m_addr;
   logic [3:0]      m_be;

   always #2 clk = ~clk;

   pci_subdec_claim #(.ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
      .devsel_n(devsel_n), .cbe_n(cbe_n), .ad(ad), .decode_off(decode_off),
      .lat_timeout(lat_timeout), .dt_ready(dt_ready), .claim(claim),
      .retry(retry), .np_mark(np_mark), .rec_valid(rec_valid),
      .rec_cmd(rec_cmd), .rec_addr(rec_addr), .rec_be_n(rec_be_n)
   );

   task automatic chk(string tag, string what, longint act, longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic run_txn(input logic [3:0] cmd, input logic [ADDR_W-1:0] addr,
                          input logic [3:0] be, input int ds, input bit off,
                          input int lat_e, input bit rdy,
                          output int ct, output int rt, output int nt,
                          output int nc, output int nr, output int nn);
      ct = -1; rt = -1; nt = -1; nc = 0; nr = 0; nn = 0;
      @(negedge clk);
      frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad = addr;
      decode_off = off; dt_ready = rdy; devsel_n = 1'b1; lat_timeout = 1'b0;
      for (int j = 0; j < 12; j++) begin
         @(negedge clk);
         if (claim)   begin nc++; if (ct < 0) ct = j; end
         if (retry)   begin nr++; if (rt < 0) rt = j; end
         if (np_mark) begin nn++; if (nt < 0) nt = j; end
         frame_n = 1'b1; irdy_n = 1'b0; cbe_n = be;
         devsel_n = (ds != 0 && j + 1 >= ds) ? 1'b0 : 1'b1;
         lat_timeout = (j + 1 >= lat_e);
      end
      @(negedge clk);
      irdy_n = 1'b1; devsel_n = 1'b1; lat_timeout = 1'b0; cbe_n = 4'hF;
      @(negedge clk);
   endtask

   task automatic chk_record(string tag);
      chk(tag, "rec_valid", rec_valid, m_v);
      if (m_v) begin
         chk(tag, "rec_cmd", rec_cmd, m_cmd);
         chk(tag, "rec_addr", rec_addr, m_addr);
         chk(tag, "rec_be_n", rec_be_n, m_be);
      end
   endtask

   task automatic run_hit(bit rdy, bit off);
      int ct, rt, nt, nc, nr, nn;
      run_txn(m_cmd, m_addr, 4'h0, 0, off, 2, rdy, ct, rt, nt, nc, nr, nn);
      chk("R8", "hit claim edge", ct, 0);
      chk("R8", "hit claim count", nc, 1);
      chk("R8", "hit retry edge", rt, rdy ? -1 : 0);
      chk("R9", "hit np edge", nt, -1);
      if (rdy) m_v = 1'b0;
      chk_record("R8");
   endtask

   function automatic int cls_of(logic [3:0] c);
      if (c == 4'h2 || c == 4'h3) return 1;
      if (c == 4'h6 || c == 4'hC || c == 4'hE) return 2;
      if (c == 4'h7 || c == 4'hF) return 3;
      return 0;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin : main
      int iter = 0;
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10", "claim in reset", claim, 0);
      chk("R10", "retry in reset", retry, 0);
      chk("R10", "np_mark in reset", np_mark, 0);
      chk("R10", "rec_valid in reset", rec_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int c = 0; c < 16; c++) begin
         for (int off = 0; off < 2; off++) begin
            for (int ds = 0; ds < 5; ds++) begin
               int ct, rt, nt, nc, nr, nn;
               int cl, ect, ert, lat_e;
               bit elig;
               string tg;
               logic [ADDR_W-1:0] a;
               logic [3:0] be;
               a = ADDR_W'(32'h0004_0000 + iter * 16);
               be = 4'(iter) ^ 4'h5;
               lat_e = (iter % 2 == 1) ? 6 : 2;
               cl = cls_of(4'(c));
               elig = (cl != 0) && (off == 0) && (ds == 0 || ds == 4);
               if (cl == 0)       tg = "R3";
               else if (off != 0) tg = "R4";
               else if (!elig)    tg = "R1";
               else               tg = "R2";
               ect = elig ? 3 : -1;
               ert = -1;
               if (elig && cl == 1) ert = 3;
               if (elig && cl == 2) ert = (lat_e > 4) ? lat_e : 4;
               run_txn(4'(c), a, be, ds, off[0], lat_e, 1'b0, ct, rt, nt, nc, nr, nn);
               chk(tg, "claim edge", ct, ect);
               chk(tg, "claim count", nc, elig ? 1 : 0);
               chk(cl == 1 ? "R5" : "R6", "retry edge", rt, ert);
               chk(cl == 1 ? "R5" : "R6", "retry count", nr, ert >= 0 ? 1 : 0);
               chk("R9", "np edge", nt, ect);
               if (ert >= 0 && !m_v) begin
                  m_v = 1'b1; m_cmd = 4'(c); m_addr = a; m_be = be;
               end
               chk_record("R7");
               if (m_v && (iter % 3 == 0)) begin
                  run_hit(1'b0, 1'b0);
                  run_hit(1'b1, 1'b1);
               end
               iter++;
            end
         end
      end

      // R10: a transaction claimed by another agent, then back-to-back idle recovery
      begin
         int ct, rt, nt, nc, nr, nn;
         run_txn(4'h3, 32'h0000_0100, 4'h0, 2, 1'b0, 2, 1'b0, ct, rt, nt, nc, nr, nn);
         chk("R10", "claim after foreign devsel", ct, -1);
         run_txn(4'h7, 32'h0000_0200, 4'h0, 0, 1'b0, 2, 1'b0, ct, rt, nt, nc, nr, nn);
         chk("R10", "claim on next access", ct, 3);
      end

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule